// File: doc/BRIEF.md
# Pipelined Burst Synchronous SRAM Model

This block is a synthesizable behavioural model of a pipelined synchronous SRAM with a four-beat burst address generator. The word is split into four equal byte lanes. A bus master starts an access with one of two active-low address strobes. The processor strobe always starts a read. The controller strobe starts a read or a write, depending on the write enables sampled on the same edge. The advance input then steps the burst through four addresses, in linear or interleaved order.

Reads go through two register stages. The access address is captured on one edge, and the array output is registered on the next. The data bus is modelled as a write-data input, a registered read-data output and a drive flag that stands in for the tri-state enable. The output enable and the sleep input gate the drive flag without waiting for a clock. While sleep is high the model ignores every other input, and both the stored contents and the burst state are kept.

Top module: `sync_burst_sram`

## Requirements
- R1: With `proc_strobe_ni` low, `sel_main_ni` low, `sel_hi_i` high and `sel_lo_ni` low, the edge loads `addr_i` and starts a read. The controller strobe and all write enables are ignored on that edge.
- R2: On an edge that accepts the processor strobe, `burst_adv_ni` and the lane selects are ignored and the burst count restarts at zero. Both inputs act on every later edge, so a write can follow at the loaded address.
- R3: The controller strobe starts a cycle only when the processor strobe is not accepted on that edge. The write enables sampled on that edge decide between read and write at `addr_i`.
- R4: When `sel_main_ni` is high, a low processor strobe is treated as absent. A controller strobe with any of the three selects inactive is a deselect. A processor strobe accepted with `sel_hi_i` low or `sel_lo_ni` high is also a deselect and writes nothing.
- R5: Lane i is bits [9i+8:9i] of the word. `global_wr_ni` low writes all four lanes. Otherwise, `byte_wr_en_ni` low writes each lane i whose `lane_wr_ni[i]` is low. When no lane is enabled, the cycle is a read.
- R6: Read data for an address registered on edge k appears on `rdata_o`, with `drive_o` high, after edge k+1. A write on edge k is visible to a read registered on edge k+1.
- R7: `drive_o` is high only while `out_en_ni` is low, `sleep_i` is low and the edge before last registered a read. A write or deselect edge turns the drive off one edge after that edge. `out_en_ni` acts without a clock.
- R8: With no strobe taken and a burst in progress, `burst_adv_ni` low steps to the next burst address. `burst_adv_ni` high repeats the current address. Each such edge is a read or a write, as decided in R5.
- R9: The upper address bits stay fixed during a burst. With `burst_ilv_i` low the low two bits are (start + count) mod 4. With it high they are start XOR count. The count wraps after four beats.
- R10: While `sleep_i` is high, no input changes the array or the burst state, and `drive_o` is low at once. After sleep ends, a burst resumes from the address it held.
- R11: After reset or after a deselect, edges with no strobe taken make no access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | ADDR_W | External word address |
| proc_strobe_ni | input | 1 | Processor address strobe, active low |
| ctrl_strobe_ni | input | 1 | Controller address strobe, active low |
| burst_adv_ni | input | 1 | Burst advance, active low |
| sel_main_ni | input | 1 | Master chip select, active low |
| sel_hi_i | input | 1 | Chip select, active high |
| sel_lo_ni | input | 1 | Chip select, active low |
| global_wr_ni | input | 1 | Write all lanes, active low |
| byte_wr_en_ni | input | 1 | Enables the lane selects, active low |
| lane_wr_ni | input | 4 | Per-lane write selects, active low |
| out_en_ni | input | 1 | Asynchronous output enable, active low |
| burst_ilv_i | input | 1 | Burst order: 1 interleaved, 0 linear |
| sleep_i | input | 1 | Power-down, active high |
| wdata_i | input | DATA_W | Write data |
| rdata_o | output | DATA_W | Registered read data |
| drive_o | output | 1 | Read-data bus drive enable |

## Verification
The embedded properties check the command decode on every cycle: strobe priority, master-select blocking, the lane mask and the sleep freeze. They also check that every drive of the output follows a read registered two edges earlier, that a non-read edge always ends the drive two edges later, and that a burst address holds when it is not stepped. Only the bench's scenarios can show that the data returned is correct: the full write and read sweep over the array, byte merges across lanes, both burst orders from every start phase, and a burst resuming after sleep, all compared with a reference array.

// File: rtl/sram_pkg.sv
package sram_pkg;
  localparam int LANES = 4;
  localparam int CNT_W = 2;

  typedef enum logic [1:0] {
    CYC_IDLE,
    CYC_DESEL,
    CYC_READ,
    CYC_WRITE
  } cyc_e;

  // low address bits of burst beat cnt from start phase base
  function automatic logic [CNT_W-1:0] burst_low(logic [CNT_W-1:0] base,
                                                 logic [CNT_W-1:0] cnt,
                                                 logic ilv);
    return ilv ? (base ^ cnt) : CNT_W'(base + cnt);
  endfunction
endpackage

// File: rtl/sram_cmd_decode.sv
module sram_cmd_decode
  import sram_pkg::*;
#(
  parameter int N_LANE = LANES
) (
  input  logic              proc_strobe_ni,
  input  logic              ctrl_strobe_ni,
  input  logic              burst_adv_ni,
  input  logic              sel_main_ni,
  input  logic              sel_hi_i,
  input  logic              sel_lo_ni,
  input  logic              global_wr_ni,
  input  logic              byte_wr_en_ni,
  input  logic [N_LANE-1:0] lane_wr_ni,
  input  logic              sleep_i,
  input  logic              burst_act_i,
  output cyc_e              kind_o,
  output logic              load_o,
  output logic              step_o,
  output logic [N_LANE-1:0] lane_we_o
);
  logic              sel_ok;
  logic              proc_hit;
  logic [N_LANE-1:0] wr_mask;

  assign sel_ok   = !sel_main_ni && sel_hi_i && !sel_lo_ni;
  assign proc_hit = !proc_strobe_ni && !sel_main_ni;

  always_comb begin
    if (!global_wr_ni)       wr_mask = '1;
    else if (!byte_wr_en_ni) wr_mask = ~lane_wr_ni;
    else                     wr_mask = '0;
  end

  always_comb begin
    kind_o    = CYC_IDLE;
    load_o    = 1'b0;
    step_o    = 1'b0;
    lane_we_o = '0;
    if (sleep_i) begin
      kind_o = CYC_IDLE;
    end else if (proc_hit) begin
      // write enables and advance are not looked at here
      if (sel_ok) begin
        kind_o = CYC_READ;
        load_o = 1'b1;
      end else begin
        kind_o = CYC_DESEL;
      end
    end else if (!ctrl_strobe_ni) begin
      if (sel_ok) begin
        load_o    = 1'b1;
        kind_o    = (|wr_mask) ? CYC_WRITE : CYC_READ;
        lane_we_o = wr_mask;
      end else begin
        kind_o = CYC_DESEL;
      end
    end else if (burst_act_i) begin
      step_o    = !burst_adv_ni;
      kind_o    = (|wr_mask) ? CYC_WRITE : CYC_READ;
      lane_we_o = wr_mask;
    end
  end
endmodule

// File: rtl/sram_burst_addr.sv
module sram_burst_addr
  import sram_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic              step_i,
  input  logic              ilv_i,
  input  logic [ADDR_W-1:0] ext_addr_i,
  output logic [ADDR_W-1:0] acc_addr_o
);
  logic [ADDR_W-1:0] base_q;
  logic [CNT_W-1:0]  cnt_q, cnt_nxt;

  assign cnt_nxt = step_i ? CNT_W'(cnt_q + 1'b1) : cnt_q;

  always_comb begin
    if (load_i) acc_addr_o = ext_addr_i;
    else        acc_addr_o = {base_q[ADDR_W-1:CNT_W],
                              burst_low(base_q[CNT_W-1:0], cnt_nxt, ilv_i)};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_q <= '0;
      cnt_q  <= '0;
    end else if (load_i) begin
      base_q <= ext_addr_i;
      cnt_q  <= '0;
    end else begin
      cnt_q  <= cnt_nxt;
    end
  end

  p_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && !step_i) ##1 (!load_i && !step_i) |-> $stable(acc_addr_o))
    else $error("burst address moved without advance");

  p_upper_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(rst_ni) && !load_i) |->
      acc_addr_o[ADDR_W-1:CNT_W] == $past(acc_addr_o[ADDR_W-1:CNT_W]))
    else $error("burst crossed its block");
endmodule

// File: rtl/sram_lane_array.sv
module sram_lane_array #(
  parameter int ADDR_W = 6,
  parameter int LANE_W = 9,
  parameter int N_LANE = 4
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic [N_LANE-1:0]        we_i,
  input  logic [ADDR_W-1:0]        waddr_i,
  input  logic [N_LANE*LANE_W-1:0] wdata_i,
  input  logic                     re_i,
  input  logic [ADDR_W-1:0]        raddr_i,
  output logic [N_LANE*LANE_W-1:0] rdata_o
);
  localparam int DEPTH = 1 << ADDR_W;

  for (genvar g = 0; g < N_LANE; g++) begin : g_lane
    logic [LANE_W-1:0] mem [DEPTH];
    logic [LANE_W-1:0] rd_q;

    always_ff @(posedge clk_i) begin
      if (we_i[g]) mem[waddr_i] <= wdata_i[g*LANE_W +: LANE_W];
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)   rd_q <= '0;
      else if (re_i) rd_q <= mem[raddr_i];
    end

    assign rdata_o[g*LANE_W +: LANE_W] = rd_q;
  end
endmodule

// File: rtl/sync_burst_sram.sv
module sync_burst_sram
  import sram_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 36
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              proc_strobe_ni,
  input  logic              ctrl_strobe_ni,
  input  logic              burst_adv_ni,
  input  logic              sel_main_ni,
  input  logic              sel_hi_i,
  input  logic              sel_lo_ni,
  input  logic              global_wr_ni,
  input  logic              byte_wr_en_ni,
  input  logic [3:0]        lane_wr_ni,
  input  logic              out_en_ni,
  input  logic              burst_ilv_i,
  input  logic              sleep_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              drive_o
);
  localparam int LANE_W = DATA_W / LANES;

  cyc_e              cmd_kind;
  logic              cmd_load, cmd_step;
  logic [LANES-1:0]  cmd_we;
  logic [ADDR_W-1:0] acc_addr;
  logic              burst_act_q;
  logic              rd_pend_q;
  logic [ADDR_W-1:0] rd_addr_q;
  logic              out_vld_q;

  sram_cmd_decode #(.N_LANE(LANES)) u_dec (
    .proc_strobe_ni, .ctrl_strobe_ni, .burst_adv_ni,
    .sel_main_ni, .sel_hi_i, .sel_lo_ni,
    .global_wr_ni, .byte_wr_en_ni, .lane_wr_ni,
    .sleep_i,
    .burst_act_i (burst_act_q),
    .kind_o      (cmd_kind),
    .load_o      (cmd_load),
    .step_o      (cmd_step),
    .lane_we_o   (cmd_we)
  );

  sram_burst_addr #(.ADDR_W(ADDR_W)) u_addr (
    .clk_i, .rst_ni,
    .load_i     (cmd_load),
    .step_i     (cmd_step),
    .ilv_i      (burst_ilv_i),
    .ext_addr_i (addr_i),
    .acc_addr_o (acc_addr)
  );

  sram_lane_array #(.ADDR_W(ADDR_W), .LANE_W(LANE_W), .N_LANE(LANES)) u_mem (
    .clk_i, .rst_ni,
    .we_i    (cmd_we),
    .waddr_i (acc_addr),
    .wdata_i (wdata_i),
    .re_i    (rd_pend_q),
    .raddr_i (rd_addr_q),
    .rdata_o (rdata_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      burst_act_q <= 1'b0;
      rd_pend_q   <= 1'b0;
      rd_addr_q   <= '0;
      out_vld_q   <= 1'b0;
    end else begin
      if (cmd_load)                    burst_act_q <= 1'b1;
      else if (cmd_kind == CYC_DESEL)  burst_act_q <= 1'b0;
      rd_pend_q <= (cmd_kind == CYC_READ);
      if (cmd_kind == CYC_READ) rd_addr_q <= acc_addr;
      // stage 2: any non-read edge clears valid one edge later
      out_vld_q <= rd_pend_q;
    end
  end

  assign drive_o = out_vld_q && !out_en_ni && !sleep_i;

  p_proc_read_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sleep_i && !proc_strobe_ni && !sel_main_ni && sel_hi_i && !sel_lo_ni)
      |-> (cmd_kind == CYC_READ && cmd_load && cmd_we == '0))
    else $error("processor strobe did not start a read");

  p_proc_first_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sleep_i && !proc_strobe_ni && !sel_main_ni) |-> (cmd_we == '0 && !cmd_step))
    else $error("controller strobe overrode processor strobe");

  p_main_block_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_main_ni && ctrl_strobe_ni) |-> !cmd_load)
    else $error("blocked processor strobe loaded an address");

  p_we_kind_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_we != '0) |-> (cmd_kind == CYC_WRITE))
    else $error("lane write outside a write cycle");

  p_global_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!global_wr_ni && cmd_kind == CYC_WRITE) |-> (&cmd_we))
    else $error("global write missed a lane");

  p_pipe_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    drive_o |-> ($past(cmd_kind, 2) == CYC_READ))
    else $error("drive without a read two edges back");

  p_scd_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_kind != CYC_READ) |-> ##2 !drive_o)
    else $error("drive not dropped after non-read edge");

  p_sleep_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sleep_i |=> $stable(burst_act_q))
    else $error("burst state changed during sleep");

  p_sleep_cmd_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sleep_i |-> (cmd_we == '0 && !cmd_load && !cmd_step))
    else $error("command accepted during sleep");

  p_idle_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!burst_act_q && proc_strobe_ni && ctrl_strobe_ni) |-> (cmd_kind == CYC_IDLE))
    else $error("access without an open burst");
endmodule

// File: tb/tb_sync_burst_sram.sv
module tb_sync_burst_sram;
  localparam int AW    = 6;
  localparam int DW    = 36;
  localparam int LW    = 9;
  localparam int DEPTH = 1 << AW;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic [AW-1:0] addr_i = '0;
  logic          proc_strobe_ni, ctrl_strobe_ni, burst_adv_ni;
  logic          sel_main_ni, sel_hi_i, sel_lo_ni;
  logic          global_wr_ni, byte_wr_en_ni;
  logic [3:0]    lane_wr_ni;
  logic          out_en_ni = 1'b0;
  logic          burst_ilv_i = 1'b0;
  logic          sleep_i;
  logic [DW-1:0] wdata_i = '0;
  logic [DW-1:0] rdata_o;
  logic          drive_o;

  always #5 clk_i = ~clk_i;

  sync_burst_sram #(.ADDR_W(AW), .DATA_W(DW)) dut (.*);

  logic [DW-1:0] ref_mem [DEPTH];
  int            n_chk = 0;
  int            n_fail = 0;
  bit            prev_rd = 1'b0;
  logic [DW-1:0] prev_exp = '0;
  string         prev_req = "";

  task automatic check(bit ok, string req, logic [DW-1:0] act, logic [DW-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] pat(int a, int s);
    return {4'(a + s), 32'(a * 32'h9E3779B1 + s * 32'h01000193)};
  endfunction

  function automatic int baddr(int base, int k, bit ilv);
    logic [1:0] b = 2'(base);
    logic [1:0] c = 2'(k);
    logic [1:0] lo = ilv ? (b ^ c) : 2'(b + c);
    return (base & ~3) | int'(lo);
  endfunction

  task automatic idle();
    proc_strobe_ni = 1'b1; ctrl_strobe_ni = 1'b1; burst_adv_ni = 1'b1;
    sel_main_ni = 1'b0; sel_hi_i = 1'b1; sel_lo_ni = 1'b0;
    global_wr_ni = 1'b1; byte_wr_en_ni = 1'b1; lane_wr_ni = 4'hf;
    sleep_i = 1'b0;
  endtask

  // one edge; rd/wr/a/m give the access expected on this edge
  task automatic tick(bit rd, bit wr, int a, logic [3:0] m, string req);
    logic [DW-1:0] cur = '0;
    bit            exp_drv;
    if (wr)
      for (int l = 0; l < 4; l++)
        if (m[l]) ref_mem[a][l*LW +: LW] = wdata_i[l*LW +: LW];
    if (rd) cur = ref_mem[a];
    @(posedge clk_i);
    @(negedge clk_i);
    exp_drv = prev_rd && !out_en_ni && !sleep_i;
    check(drive_o == exp_drv, {prev_req, "/R7 drive"}, DW'(drive_o), DW'(exp_drv));
    if (exp_drv)
      check(rdata_o == prev_exp, {prev_req, "/R6 data"}, rdata_o, prev_exp);
    prev_rd  = rd;
    prev_exp = cur;
    prev_req = req;
  endtask

  task automatic desel();
    idle(); ctrl_strobe_ni = 1'b0; sel_hi_i = 1'b0;
    tick(0, 0, 0, 4'h0, "R4");
  endtask

  task automatic proc_read(int a, string req);
    idle(); proc_strobe_ni = 1'b0; addr_i = AW'(a);
    tick(1, 0, a, 4'h0, req);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    idle();
    repeat (3) @(negedge clk_i);
    check(drive_o == 1'b0, "R7 reset", DW'(drive_o), '0);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // R3 / R5: fill every word through controller-strobe global writes
    for (int a = 0; a < DEPTH; a++) begin
      idle(); ctrl_strobe_ni = 1'b0; global_wr_ni = 1'b0;
      addr_i = AW'(a); wdata_i = pat(a, 1);
      tick(0, 1, a, 4'hf, "R3");
    end
    desel();

    // R1: processor strobe reads; write enables and controller strobe ignored
    for (int a = 0; a < DEPTH; a++) begin
      idle(); proc_strobe_ni = 1'b0; ctrl_strobe_ni = 1'b0;
      global_wr_ni = 1'b0; byte_wr_en_ni = 1'b0; lane_wr_ni = 4'h0;
      addr_i = AW'(a); wdata_i = ~pat(a, 1);
      tick(1, 0, a, 4'h0, "R1");
    end
    desel();

    // R8 / R9: bursts in both orders from many start phases
    for (int ilv = 0; ilv < 2; ilv++) begin
      burst_ilv_i = 1'(ilv);
      for (int base = 0; base < DEPTH; base += 5) begin
        proc_read(base, "R9");
        for (int k = 1; k < 4; k++) begin
          idle(); burst_adv_ni = 1'b0;
          tick(1, 0, baddr(base, k, 1'(ilv)), 4'h0, "R9");
        end
        idle();
        tick(1, 0, baddr(base, 3, 1'(ilv)), 4'h0, "R8");
        idle(); burst_adv_ni = 1'b0;
        tick(1, 0, base, 4'h0, "R8");
        desel();
      end
    end
    burst_ilv_i = 1'b0;

    // R5: lane-masked write bursts, then read back
    for (int i = 0; i < 4; i++) begin
      int base = 8 + i * 13;
      idle(); ctrl_strobe_ni = 1'b0; byte_wr_en_ni = 1'b0;
      lane_wr_ni = ~(4'b0101 << (i % 2)); addr_i = AW'(base); wdata_i = pat(base, 7 + i);
      tick(0, 1, base, ~lane_wr_ni, "R5");
      for (int k = 1; k < 4; k++) begin
        idle(); burst_adv_ni = 1'b0; byte_wr_en_ni = 1'b0;
        lane_wr_ni = 4'(~(4'b1001 << k) | (4'(i) & 4'b0010));
        if (lane_wr_ni == 4'hf) lane_wr_ni = 4'b0111;
        wdata_i = pat(base + k, 20 + i);
        tick(0, 1, baddr(base, k, 0), ~lane_wr_ni, "R5");
      end
      desel();
      proc_read(base, "R5");
      for (int k = 1; k < 4; k++) begin
        idle(); burst_adv_ni = 1'b0;
        tick(1, 0, baddr(base, k, 0), 4'h0, "R5");
      end
      desel();
    end

    // R5: global write overrides lane selects; no lane means read
    idle(); ctrl_strobe_ni = 1'b0; global_wr_ni = 1'b0; addr_i = AW'(30);
    wdata_i = pat(30, 99);
    tick(0, 1, 30, 4'hf, "R5");
    desel();
    idle(); ctrl_strobe_ni = 1'b0; byte_wr_en_ni = 1'b0; addr_i = AW'(31);
    wdata_i = pat(31, 55);
    tick(1, 0, 31, 4'h0, "R5");
    idle(); lane_wr_ni = 4'h0;
    tick(1, 0, 31, 4'h0, "R5");
    desel();
    proc_read(30, "R5");
    desel();

    // R2: processor-started write; advance and selects ignored on load edge
    idle(); proc_strobe_ni = 1'b0; byte_wr_en_ni = 1'b0; lane_wr_ni = 4'h0;
    burst_adv_ni = 1'b0; addr_i = AW'(40); wdata_i = pat(40, 3);
    tick(1, 0, 40, 4'h0, "R2");
    idle(); byte_wr_en_ni = 1'b0; lane_wr_ni = 4'h0; wdata_i = pat(40, 4);
    tick(0, 1, 40, 4'hf, "R2");
    idle(); burst_adv_ni = 1'b0; byte_wr_en_ni = 1'b0; lane_wr_ni = 4'b1100;
    wdata_i = pat(41, 5);
    tick(0, 1, 41, 4'b0011, "R2");
    desel();
    proc_read(40, "R2");
    idle(); burst_adv_ni = 1'b0;
    tick(1, 0, 41, 4'h0, "R2");
    desel();

    // R4 / R11: master select blocks the processor strobe only
    proc_read(50, "R4");
    idle(); proc_strobe_ni = 1'b0; sel_main_ni = 1'b1; burst_adv_ni = 1'b0;
    addr_i = AW'(3);
    tick(1, 0, 51, 4'h0, "R4");
    idle(); proc_strobe_ni = 1'b0; sel_main_ni = 1'b1; ctrl_strobe_ni = 1'b0;
    tick(0, 0, 0, 4'h0, "R4");
    idle(); burst_adv_ni = 1'b0;
    tick(0, 0, 0, 4'h0, "R11");
    idle(); burst_adv_ni = 1'b0; byte_wr_en_ni = 1'b0; lane_wr_ni = 4'h0;
    wdata_i = pat(0, 66);
    tick(0, 0, 0, 4'h0, "R11");
    idle(); ctrl_strobe_ni = 1'b0; sel_lo_ni = 1'b1; global_wr_ni = 1'b0;
    addr_i = AW'(52); wdata_i = pat(52, 77);
    tick(0, 0, 0, 4'h0, "R4");
    idle(); proc_strobe_ni = 1'b0; ctrl_strobe_ni = 1'b0; sel_hi_i = 1'b0;
    global_wr_ni = 1'b0; addr_i = AW'(52); wdata_i = pat(52, 78);
    tick(0, 0, 0, 4'h0, "R4");
    proc_read(52, "R4");
    proc_read(0, "R11");
    desel();

    // R10: sleep freezes array and burst, drops drive at once
    proc_read(20, "R10");
    idle(); burst_adv_ni = 1'b0;
    tick(1, 0, 21, 4'h0, "R10");
    sleep_i = 1'b1; ctrl_strobe_ni = 1'b0; global_wr_ni = 1'b0;
    addr_i = AW'(60); wdata_i = pat(60, 88);
    #1;
    check(drive_o == 1'b0, "R10 immediate", DW'(drive_o), '0);
    tick(0, 0, 0, 4'h0, "R10");
    tick(0, 0, 0, 4'h0, "R10");
    idle(); burst_adv_ni = 1'b0;
    tick(1, 0, 22, 4'h0, "R10");
    desel();
    proc_read(60, "R10");
    desel();

    // R7: output enable acts without a clock
    proc_read(10, "R7");
    desel();
    out_en_ni = 1'b1;
    #1;
    check(drive_o == 1'b0, "R7 oe off", DW'(drive_o), '0);
    out_en_ni = 1'b0;
    #1;
    check(drive_o == 1'b1, "R7 oe on", DW'(drive_o), DW'(1));
    check(rdata_o == ref_mem[10], "R6 oe data", rdata_o, ref_mem[10]);
    desel();
    desel();

    summary();
    $finish;
  end
endmodule